// File: doc/BRIEF.md
# Non-Preemptive Priority Interrupt Scheduler

This block gathers interrupt requests from a fixed set of sources and hands them one at a time to the main controller. Each source owns a fixed rank. Source 0 carries communication traffic and outranks all the others. After it, rank falls with the index.

While the main program runs undisturbed, any pending request makes the scheduler raise a one-cycle preempt pulse. A one-cycle dispatch pulse follows in the next cycle and carries the binary index of the chosen source. The handler then owns the controller until it pulses finish. New requests never cut into a running handler. They are latched as sticky pending bits.

On finish, the scheduler dispatches the best remaining source straight away. If nothing is pending, it pulses return and falls back to idle. The handlers themselves live outside the block.

Top module: `irq_np_sched`

## Requirements
- R1: While rst_ni is low, and after reset with no request, preempt_o, dispatch_o, ret_o and id_o all stay 0, and no source is pending.
- R2: From idle, a request on req_i seen at clock edge k gives preempt_o high for exactly the cycle after edge k+1. dispatch_o is high in the following cycle.
- R3: At dispatch, id_o is the binary index of the lowest-numbered pending source. Source 0 has the highest rank and source 3 the lowest. id_o is 0 whenever dispatch_o is low.
- R4: Between a dispatch and the next finish_i pulse, preempt_o and dispatch_o stay low, whatever req_i does.
- R5: A request that arrives while a handler runs stays pending and is dispatched later. It is never dropped.
- R6: If any source is pending, or is requested, in the cycle finish_i is high during a handler, dispatch_o rises in the next cycle and no preempt_o pulse comes first.
- R7: If no source is pending or requested in that finish cycle, ret_o is high for exactly one cycle in the next cycle, and the block then returns to idle.
- R8: The pending bit of a dispatched source is cleared in its dispatch cycle. A request on that same source in that same cycle keeps it pending, so it is dispatched again later.
- R9: finish_i has no effect unless a handler is running. Pulses while idle produce no output activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Request per source; a high cycle latches the source as pending |
| finish_i | input | 1 | Handler-complete pulse |
| preempt_o | output | 1 | One-cycle pulse that suspends the main program |
| dispatch_o | output | 1 | One-cycle pulse; id_o is valid with it |
| id_o | output | 2 | Index of the dispatched source |
| ret_o | output | 1 | One-cycle pulse that hands control back to the main program |

## Verification
The bench aims at the cycle where a handler finishes. It sends requests in that very cycle and in the cycles around it. A design that consulted only the registered pending bits would wrongly emit return and then preempt. The bench also re-requests a source in its own dispatch cycle. A design that gave the clear precedence would lose that request for good.

Requests during a running handler come in bursts of mixed rank. Early service of a higher-rank source would show up as a mid-handler dispatch. A wrong tie rule would show up as a bad id_o. Random traffic, with finish pulses sprinkled into idle periods, catches any scheduler that reacts to a stray finish.

// File: rtl/irq_np_sched_pkg.sv
package irq_np_sched_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_DISP = 3'd2,
    ST_RUN  = 3'd3,
    ST_RET  = 3'd4
  } sched_st_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    logic bit_q;
    // set wins over clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= (bit_q & ~clr_i[g]) | set_i[g];
    end
    assign pend_o[g] = bit_q;

    p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bit_q && !clr_i[g]) |=> bit_q);
    p_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> bit_q);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] vec_i,
  output logic [ID_W-1:0]  id_o,
  output logic             any_o
);
  // lowest index has top rank
  always_comb begin
    id_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) id_o = ID_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/irq_sched_fsm.sv
module irq_sched_fsm
  import irq_np_sched_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_any_i,
  input  logic next_any_i,
  input  logic finish_i,
  output logic preempt_o,
  output logic dispatch_o,
  output logic ret_o
);
  sched_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (pend_any_i) st_d = ST_PRE;
      ST_PRE:  st_d = ST_DISP;
      ST_DISP: st_d = ST_RUN;
      ST_RUN:  if (finish_i) st_d = next_any_i ? ST_DISP : ST_RET;
      ST_RET:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign preempt_o  = (st_q == ST_PRE);
  assign dispatch_o = (st_q == ST_DISP);
  assign ret_o      = (st_q == ST_RET);

  p_hold_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !finish_i) |=> (st_q == ST_RUN));
  p_ret_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_o |=> (st_q == ST_IDLE));
endmodule

// File: rtl/irq_np_sched.sv
module irq_np_sched #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             finish_i,
  output logic             preempt_o,
  output logic             dispatch_o,
  output logic [ID_W-1:0]  id_o,
  output logic             ret_o
);
  logic [N_SRC-1:0] pend_q, clr;
  logic [ID_W-1:0]  pick_id;
  logic             pend_any;

  irq_pend_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend_q)
  );

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .vec_i (pend_q),
    .id_o  (pick_id),
    .any_o (pend_any)
  );

  irq_sched_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_any_i (pend_any),
    .next_any_i (pend_any | (|req_i)),
    .finish_i   (finish_i),
    .preempt_o  (preempt_o),
    .dispatch_o (dispatch_o),
    .ret_o      (ret_o)
  );

  always_comb begin
    clr = '0;
    if (dispatch_o) clr[pick_id] = 1'b1;
  end

  assign id_o = dispatch_o ? pick_id : '0;

  p_pre_disp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preempt_o |=> (dispatch_o && !preempt_o));
  p_disp_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_o |-> pend_q[id_o]);
  p_no_redisp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_o |=> (!dispatch_o && !preempt_o));
  p_ret_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_o |=> (!ret_o && !dispatch_o && !preempt_o));
  p_id_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dispatch_o |-> (id_o == '0));
endmodule

// File: tb/irq_np_sched_tb_top.sv
`timescale 1ns/1ps
module irq_np_sched_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_i = '0;
  logic       finish_i = 1'b0;
  logic       preempt_o, dispatch_o, ret_o;
  logic [1:0] id_o;

  int checks = 0;
  int failures = 0;

  // reference model: 0 idle, 1 preempt, 2 dispatch, 3 running, 4 return
  int m_st = 0;
  bit [3:0] m_pend = '0;

  always #10 clk_i = ~clk_i;

  irq_np_sched dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .finish_i   (finish_i),
    .preempt_o  (preempt_o),
    .dispatch_o (dispatch_o),
    .id_o       (id_o),
    .ret_o      (ret_o)
  );

  function automatic int top_src(bit [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "preempt_o",  int'(preempt_o),  (m_st == 1) ? 1 : 0);
    chk(tag, "dispatch_o", int'(dispatch_o), (m_st == 2) ? 1 : 0);
    chk(tag, "ret_o",      int'(ret_o),      (m_st == 4) ? 1 : 0);
    chk(tag, "id_o",       int'(id_o),       (m_st == 2) ? top_src(m_pend) : 0);
  endtask

  task automatic model_step(bit [3:0] rq, bit fn);
    bit [3:0] clr = '0;
    int nst = m_st;
    case (m_st)
      0: if (m_pend != 0) nst = 1;
      1: nst = 2;
      2: begin clr[top_src(m_pend)] = 1'b1; nst = 3; end
      3: if (fn) nst = ((m_pend | rq) != 0) ? 2 : 4;
      default: nst = 0;
    endcase
    m_pend = (m_pend & ~clr) | rq;
    m_st = nst;
  endtask

  // compare the current cycle, then drive the next inputs
  task automatic step(bit [3:0] rq, bit fn, string tag);
    @(negedge clk_i);
    compare(tag);
    req_i = rq;
    finish_i = fn;
    model_step(rq, fn);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step('0, 1'b0, tag);
  endtask

  // pulse finish once a handler is running
  task automatic finish_one(string tag);
    for (int i = 0; i < 20 && m_st != 3; i++) step('0, 1'b0, tag);
    step('0, 1'b1, tag);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      compare("R1");
    end
    rst_ni = 1'b1;
    idle(4, "R1");

    // R9: stray finish while idle
    for (int i = 0; i < 3; i++) step('0, 1'b1, "R9");
    idle(3, "R9");

    // R2 + R7: single request, then drain
    step(4'b0100, 1'b0, "R2");
    idle(4, "R2");
    finish_one("R7");
    idle(4, "R7");

    // R3 + R6: simultaneous requests drained in rank order
    step(4'b1110, 1'b0, "R3");
    idle(3, "R3");
    finish_one("R6");
    idle(2, "R3");
    finish_one("R6");
    idle(2, "R3");
    finish_one("R7");
    idle(3, "R7");

    // R4 + R5: arrivals of higher rank during a handler
    step(4'b1000, 1'b0, "R4");
    idle(4, "R4");
    step(4'b0100, 1'b0, "R4");
    step(4'b0001, 1'b0, "R4");
    idle(6, "R4");
    finish_one("R5");
    idle(2, "R5");
    finish_one("R5");
    idle(2, "R5");
    finish_one("R7");
    idle(3, "R7");

    // R6: request in the very finish cycle of a lone handler
    step(4'b0010, 1'b0, "R6");
    idle(4, "R6");
    step(4'b1000, 1'b1, "R6");
    idle(3, "R6");
    finish_one("R7");
    idle(3, "R7");

    // R8: same source re-requested in its dispatch cycle
    step(4'b0100, 1'b0, "R8");
    for (int i = 0; i < 10 && m_st != 2; i++) step('0, 1'b0, "R8");
    step(4'b0100, 1'b0, "R8");
    idle(3, "R8");
    finish_one("R8");
    idle(3, "R8");
    finish_one("R7");
    idle(3, "R7");

    // random traffic
    for (int i = 0; i < 600; i++) begin
      bit [3:0] rq = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'b0;
      bit fn = ($urandom_range(0, 3) == 0);
      step(rq, fn, "R5");
    end
    for (int i = 0; i < 40; i++) step('0, (m_st == 3), "R7");
    idle(3, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule